// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous system port and an external 8-bit asynchronous static RAM with an 18-bit address. The memory has two chip selects, one active low and one active high, plus an active-low write strobe and an active-low read strobe. The system side offers one read or one write at a time on a valid/ready handshake. The block accepts the request and then drives the memory pins from registers, so that every minimum time the memory needs is met. Reads return their byte with a one-cycle response strobe.

Every nanosecond limit is a parameter. It is turned into a cycle count by ceiling division by `CLK_PERIOD_NS`, and no count is ever less than one cycle. A write is the overlap of both selects being active and the write strobe being low. The sequencer opens that overlap in the same cycle it applies the address. It waits out the memory's float time before turning on its own data driver, and it ends the overlap, drops the driver and releases the address on a single clock edge.

The bidirectional data bus is split into `mem_dq_out`, `mem_dq_in` and `mem_dq_oe`. The state machine has seven states:
- IDLE: ready, pins inactive.
- RD_ACCESS: selects, read strobe low, address held.
- RD_CAPTURE: data latched, response strobe, pins released.
- TURNAROUND: waits for the memory to float its bus after a read.
- WR_SETUP: selects and write strobe low, driver off.
- WR_PULSE: driver on.
- WR_RECOVER: a gap after the write strobe rises.

The transitions are:
- IDLE→RD_ACCESS or IDLE→WR_SETUP on an accepted request.
- RD_ACCESS→RD_CAPTURE when the access count expires.
- RD_CAPTURE→TURNAROUND always.
- TURNAROUND→IDLE when the float count expires.
- WR_SETUP→WR_PULSE when the float count expires.
- WR_PULSE→WR_RECOVER when the pulse count expires.
- WR_RECOVER→IDLE when the recovery count expires.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset `req_ready`=1, `rsp_valid`=0, `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: `req_ready` is high only in IDLE. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. Requests offered while busy have no effect on the memory.
- R3: A read holds `mem_cs_n`=0, `mem_cs`=1, `mem_oe_n`=0 and `mem_we_n`=1 for RDC cycles, where RDC = max(ceil(70/P), ceil(35/P)) and P=`CLK_PERIOD_NS`. In the cycle after those RDC cycles, `rsp_valid` is high for exactly one cycle with the byte sampled from `mem_dq_in`. `mem_oe_n` is never low while `mem_we_n` is low.
- R4: A write holds both selects active and `mem_we_n` low for SU+PW cycles while `mem_oe_n` stays high. SU = ceil(25/P). PW = max(ceil(30/P), ceil(70/P)−SU, ceil(60/P)−SU, ceil(50/P)−SU, 1). With P=8 this gives 9 cycles.
- R5: `mem_dq_oe` is high only while `mem_we_n` is low. It rises SU cycles after `mem_we_n` falls, stays high for the last PW cycles of the write, and falls on the same edge that raises `mem_we_n`.
- R6: `mem_addr` is stable while a select is active and equals the accepted address. `mem_dq_out` equals the accepted write byte while driven.
- R7: `req_ready` returns SU+PW+RC+1 cycles after a write is accepted, with RC = ceil(10/P). It returns RDC+1+TA+1 cycles after a read is accepted, with TA = max(ceil(25/P), 1).
- R8: A read returns the byte most recently written to that address.
- R9: The sequence respects the memory's pulse-width, data-setup, address-setup, cycle-time and bus-contention limits at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte valid, one cycle |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Enable for the data driver |

## Verification
The bench builds the block with its default parameters: P = 8 ns, which matches the 125 MHz bench clock, and the default nanosecond limits. This gives SU=4, PW=5, RC=2, RDC=9 and TA=4. These values make SU a real wait of several cycles, so the driver turn-on point, the split of the strobe between WR_SETUP and WR_PULSE, and the cycle-time limit (not the pulse-width limit) deciding PW can all be observed. A cycle-counting memory model returns wrong data when a read is sampled too early, and counts every pulse, setup, cycle-time or contention breach. Random reads and writes over a small address set are mixed with directed back-to-back turnarounds and requests held during busy periods.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_TURNAROUND,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } seq_state_e;

    // Ceiling of a nanosecond limit over the clock period, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RD_CYC  = 9,
    parameter int TA_CYC  = 4,
    parameter int SU_CYC  = 4,
    parameter int PW_CYC  = 5,
    parameter int RC_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             mem_cs_n,
    output logic             mem_cs,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic             mem_dq_oe
);

    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);
    localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] PW_LD = CNT_W'(PW_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LD = CNT_W'(RC_CYC - 1);

    seq_state_e state_q, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Next state and dwell count
    always_comb begin
        state_nxt = state_q;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_nxt = ST_WR_SETUP;
                        tmr_val   = SU_LD;
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        tmr_val   = RD_LD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) state_nxt = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                state_nxt = ST_TURNAROUND;
                tmr_val   = TA_LD;
            end
            ST_TURNAROUND: begin
                if (tmr_done) state_nxt = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    state_nxt = ST_WR_PULSE;
                    tmr_val   = PW_LD;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_nxt = ST_WR_RECOVER;
                    tmr_val   = RC_LD;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_done) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_nxt != state_q);
    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign capture  = (state_q == ST_RD_ACCESS) && (state_nxt == ST_RD_CAPTURE);

    // Registered pin and handshake outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_ready <= 1'b1;
            rsp_valid <= 1'b0;
            mem_cs_n  <= 1'b1;
            mem_cs    <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            req_ready <= 1'b0;
            rsp_valid <= 1'b0;
            mem_cs_n  <= 1'b1;
            mem_cs    <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            unique case (state_nxt)
                ST_IDLE: req_ready <= 1'b1;
                ST_RD_ACCESS: begin
                    mem_cs_n <= 1'b0;
                    mem_cs   <= 1'b1;
                    mem_oe_n <= 1'b0;
                end
                ST_RD_CAPTURE: rsp_valid <= 1'b1;
                ST_TURNAROUND: ;
                ST_WR_SETUP: begin
                    mem_cs_n <= 1'b0;
                    mem_cs   <= 1'b1;
                    mem_we_n <= 1'b0;
                end
                ST_WR_PULSE: begin
                    mem_cs_n  <= 1'b0;
                    mem_cs    <= 1'b1;
                    mem_we_n  <= 1'b0;
                    mem_dq_oe <= 1'b1;
                end
                ST_WR_RECOVER: ;
                default: ;
            endcase
        end
    end

    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r3_no_read_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs));

    a_r3_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_cs));

    a_r5_release_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> $rose(mem_we_n));

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rsp_rdata <= '0;
        else if (capture) rsp_rdata <= mem_dq_in;
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_ACE_NS      = 70,
    parameter int T_DOE_NS      = 35,
    parameter int T_HZOE_NS     = 25,
    parameter int T_HZCE_NS     = 25,
    parameter int T_WC_NS       = 70,
    parameter int T_SCE_NS      = 60,
    parameter int T_AW_NS       = 60,
    parameter int T_PWE_NS      = 50,
    parameter int T_SD_NS       = 30,
    parameter int T_HZWE_NS     = 25,
    parameter int T_LZWE_NS     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int P = CLK_PERIOD_NS;
    localparam int RD_CYC = imax(imax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_ACE_NS, P)),
                                 imax(ns_to_cyc(T_DOE_NS, P), ns_to_cyc(T_RC_NS, P)));
    localparam int TA_CYC = imax(ns_to_cyc(T_HZOE_NS, P), ns_to_cyc(T_HZCE_NS, P));
    localparam int SU_CYC = ns_to_cyc(T_HZWE_NS, P);
    localparam int PW_CYC = imax(imax(ns_to_cyc(T_SD_NS, P), 1),
                            imax(imax(ns_to_cyc(T_WC_NS, P) - SU_CYC, ns_to_cyc(T_AW_NS, P) - SU_CYC),
                                 imax(ns_to_cyc(T_PWE_NS, P) - SU_CYC, ns_to_cyc(T_SCE_NS, P) - SU_CYC)));
    localparam int RC_CYC = ns_to_cyc(T_LZWE_NS, P);
    localparam int MAX_CYC = imax(imax(RD_CYC, TA_CYC), imax(imax(SU_CYC, PW_CYC), RC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int WE_LOW_CYC = imax(imax(ns_to_cyc(T_PWE_NS, P), ns_to_cyc(T_WC_NS, P)),
                                     ns_to_cyc(T_AW_NS, P));

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .TA_CYC (TA_CYC),
        .SU_CYC (SU_CYC),
        .PW_CYC (PW_CYC),
        .RC_CYC (RC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .mem_cs_n  (mem_cs_n),
        .mem_cs    (mem_cs),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_rdata  (rsp_rdata)
    );

    // Run length of the write strobe, kept for the width check below
    logic [15:0] we_low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            we_low_run <= '0;
        else if (mem_we_n)                     we_low_run <= '0;
        else if (we_low_run != 16'hFFFF)       we_low_run <= we_low_run + 16'd1;
    end

    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (32'(we_low_run) >= WE_LOW_CYC));

    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb;

    localparam int PER = 8;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int SU  = cdiv(25);
    localparam int PW  = mx(mx(cdiv(30), 1), mx(cdiv(70) - SU, mx(cdiv(60) - SU, cdiv(50) - SU)));
    localparam int RC  = cdiv(10);
    localparam int RDC = mx(cdiv(70), cdiv(35));
    localparam int TA  = cdiv(25);
    localparam int WC  = cdiv(70);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int checks = 0;
    int errors = 0;
    int viol   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sram_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- cycle-counting memory model ----------------
    logic [7:0]  marr [256];
    int          addr_run = 100, oe_run = 0, we_run = 0, drv_run = 0;
    logic [17:0] last_addr = '0;
    bit          prev_wr = 0, prev_oe = 0;
    int          prev_we_run = 0, prev_drv_run = 0, prev_addr_run = 0;
    logic [7:0]  prev_dq = '0;

    wire sel     = !mem_cs_n && mem_cs;
    wire mem_drv = sel && !mem_oe_n && mem_we_n;

    assign mem_dq_in = (mem_drv && addr_run >= RDC && oe_run >= cdiv(35))
                       ? marr[mem_addr[7:0]] : ~marr[mem_addr[7:0]];

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_addr != last_addr) begin
                if (addr_run < WC) viol++;
                addr_run = 1;
            end else addr_run++;
            last_addr = mem_addr;
            oe_run = (sel && !mem_oe_n) ? oe_run + 1 : 0;
            we_run = (sel && !mem_we_n) ? we_run + 1 : 0;
            drv_run = mem_dq_oe ? drv_run + 1 : 0;
            if (mem_dq_oe && mem_drv) viol++;
            if (mem_dq_oe && we_run < SU + 1) viol++;
            if (prev_wr && !(sel && !mem_we_n)) begin
                if (prev_we_run < cdiv(50)) viol++;
                if (prev_addr_run < cdiv(60)) viol++;
                if (!prev_oe || prev_drv_run < cdiv(30)) viol++;
                marr[last_addr[7:0]] = prev_dq;
            end
            prev_wr = sel && !mem_we_n;
            prev_oe = mem_dq_oe;
            prev_we_run = we_run;
            prev_drv_run = drv_run;
            prev_addr_run = addr_run;
            prev_dq = mem_dq_out;
        end
    end

    // ---------------- bench helpers ----------------
    logic [7:0] ref_mem [256];

    function automatic logic [17:0] addr_of(input logic [7:0] i);
        return {i ^ 8'h5A, 2'b10, i};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] d);
        int we_cnt, first_dq, last_dq, ready_c;
        bit oe_bad, pin_bad, busy_ready;
        we_cnt = 0; first_dq = 0; last_dq = 0; ready_c = 0;
        oe_bad = 0; pin_bad = 0; busy_ready = 0;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = addr_of(idx); req_wdata = d;
        @(posedge clk);
        for (int c = 1; c < 40; c++) begin
            @(negedge clk);
            req_valid = 0;
            if (req_ready) begin ready_c = c; break; end
            if (!mem_we_n) we_cnt++;
            if (!mem_oe_n) oe_bad = 1;
            if (mem_dq_oe) begin
                if (first_dq == 0) first_dq = c;
                last_dq = c;
                if (mem_dq_out != d) pin_bad = 1;
            end
            if (sel && mem_addr != addr_of(idx)) pin_bad = 1;
        end
        ref_mem[idx] = d;
        chk(we_cnt == SU + PW, "R4 write strobe length", we_cnt, SU + PW);
        chk(!oe_bad, "R4 read strobe high in write", oe_bad, 0);
        chk(first_dq == SU + 1, "R5 driver on", first_dq, SU + 1);
        chk(last_dq == SU + PW, "R5 driver off", last_dq, SU + PW);
        chk(!pin_bad, "R6 address/data held", pin_bad, 0);
        chk(ready_c == SU + PW + RC + 1, "R7 write ready return", ready_c, SU + PW + RC + 1);
        chk(!busy_ready, "R2 ready low when busy", busy_ready, 0);
    endtask

    task automatic do_read(input logic [7:0] idx, input bit hold_junk);
        int oe_cnt, rsp_c, rsp_n, ready_c;
        logic [7:0] got;
        oe_cnt = 0; rsp_c = 0; rsp_n = 0; ready_c = 0; got = '0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = addr_of(idx);
        @(posedge clk);
        for (int c = 1; c < 40; c++) begin
            @(negedge clk);
            if (hold_junk) begin
                req_valid = 1; req_write = 1; req_wdata = ~ref_mem[idx];
            end else req_valid = 0;
            if (req_ready) begin ready_c = c; req_valid = 0; break; end
            if (!mem_oe_n && mem_we_n) oe_cnt++;
            if (rsp_valid) begin rsp_c = c; rsp_n++; got = rsp_rdata; end
        end
        chk(oe_cnt == RDC, "R3 read strobe length", oe_cnt, RDC);
        chk(rsp_c == RDC + 1 && rsp_n == 1, "R3 response cycle", rsp_c, RDC + 1);
        chk(got == ref_mem[idx], "R8 read data", got, ref_mem[idx]);
        chk(ready_c == RDC + 1 + TA + 1, "R7 read ready return", ready_c, RDC + TA + 2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin marr[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid, "R1 handshake reset", {req_ready, rsp_valid}, 2);
        chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 pins reset",
            {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R2: offered while rst released but no valid: nothing moves
        chk(mem_cs_n && req_ready, "R2 idle without request", mem_cs_n, 1);

        // directed corners
        do_write(8'h00, 8'h00);
        do_write(8'hFF, 8'hFF);
        do_read(8'hFF, 0);
        do_read(8'h00, 0);
        do_write(8'h10, 8'hA5);
        do_read(8'h10, 1);   // R2: request held high during busy must not write
        do_read(8'h10, 0);
        do_write(8'h10, 8'h3C);
        do_write(8'h10, 8'hC3);
        do_read(8'h10, 0);

        // random mix over 32 locations
        for (int n = 0; n < 300; n++) begin
            logic [7:0] idx;
            idx = 8'($urandom_range(0, 31)) * 8'd7;
            if ($urandom_range(0, 1) == 1) do_write(idx, 8'($urandom));
            else do_read(idx, $urandom_range(0, 7) == 0);
        end

        repeat (4) @(negedge clk);
        chk(viol == 0, "R9 memory timing violations", viol, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule